// File: doc/BRIEF.md
# IO Virtual Address Translator

This block converts DMA addresses issued by IO devices into physical memory addresses. Translation entries sit in a page table in main memory. The top of the 32-bit address space forms a translation window, and its size can be programmed. A device address inside the window selects one table entry. An 8-entry fully associative translation cache keeps recently used entries, so a repeated page does not need another table read.

A device slot can be put in bypass. Its addresses then go straight through as physical addresses, and physical bit 30 comes from that slot's configuration. Software programs the block through a simple register-write port. The same port invalidates either the whole translation cache or a single page of it.

Requests are handled one at a time by a three-state walker:
- **IDLE** accepts a request. It moves to **RESP** when the answer is known at once: bypass, translation disabled, address outside the window, or a cache hit. It moves to **FETCH** on a cache miss.
- **FETCH** holds a single 32-bit table read until memory answers. It then moves to **RESP**.
- **RESP** presents the result for one cycle and returns to **IDLE**.

Top module: `iova_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` is 0 and `mem_req` is 0.
- R2: Register 0 holds the control fields: bit 0 enables translation and bits 4:2 are the range code. When bit 0 is clear and the slot is not in bypass, the response carries `resp_pa = req_va[30:0]` with no fault and no memory read. This response comes one cycle after acceptance, and every response is a single-cycle `resp_valid` pulse.
- R3: Register 4+s is the configuration of slot s. When its bit 0 is set, requests from slot s get `resp_pa = {cfg[16], req_va[29:0]}` with no fault and no memory read, whether translation is enabled or not.
- R4: With translation enabled, range code n gives a window that starts at 2^32 − 2^(24+n) and runs to 0xFFFFFFFF. An address below the window faults one cycle after acceptance, with no memory read and `resp_pa` = 0.
- R5: On a cache miss inside the window, `mem_req` rises with `mem_addr` = base + ((va − window start) >> 12) × 4, where base is register 1. It stays high with a stable address until `mem_rvalid`, and the response follows in the next cycle.
- R6: A table entry carries the physical page number in bits 26:8, cacheable in bit 7, writable in bit 2 and valid in bit 1. A good translation returns `resp_pa = {entry[26:8], va[11:0]}` and `resp_cacheable = entry[7]`.
- R7: An entry whose valid bit is clear gives a fault with `resp_pa` = 0. It is not cached, so the next access to that page reads the table again.
- R8: A write request to an entry whose writable bit is clear faults. The valid entry is still cached, and a read of that page then hits.
- R9: A request that hits the cache responds one cycle after acceptance and issues no memory read.
- R10: The cache holds 8 pages with round-robin replacement. After 9 distinct pages are filled, the first one misses and the other 8 hit.
- R11: A write of any value to register 2 invalidates every cached page.
- R12: A write to register 3 invalidates only the cached page equal to `wdata[31:12]`. Other pages still hit.
- R13: If a register 2 or 3 write occurs while a table read is outstanding, the fetched entry still produces the response but is not cached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW (3) | Register index |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Device request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_va | input | 32 | Device virtual address |
| req_write | input | 1 | Request is a write |
| req_slot | input | SLOT_W (2) | Requesting slot |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_fault | output | 1 | Translation fault |
| resp_pa | output | 31 | Physical address |
| resp_cacheable | output | 1 | Entry marked cacheable |
| mem_req | output | 1 | Table read request, held until answered |
| mem_addr | output | 32 | Table entry address |
| mem_rvalid | input | 1 | Table read data valid |
| mem_rdata | input | 32 | Table entry |

## Verification
Cache state that is wrong shows up one cycle after acceptance. A page that should hit raises `mem_req`, and a page that should miss answers with no table read. The bench therefore records both latency and memory traffic for every request. A corrupt entry or window decode appears in the same response as a wrong `resp_pa`, `resp_cacheable` or `mem_addr`. A walker stuck in FETCH or RESP shows as a `resp_valid` that never arrives or never drops.

// File: rtl/iova_pkg.sv
`timescale 1ns/1ps
package iova_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_RESP  = 2'd2
    } walk_state_t;

    localparam int REG_CTRL       = 0;
    localparam int REG_BASE       = 1;
    localparam int REG_FLUSH_ALL  = 2;
    localparam int REG_FLUSH_PAGE = 3;
    localparam int REG_SLOT0      = 4;

    localparam int PG_SH   = 12;
    localparam int VPN_W   = 32 - PG_SH;
    localparam int PPN_W   = 19;
    localparam int E_PPN_LO = 8;
    localparam int E_PPN_HI = E_PPN_LO + PPN_W - 1;
    localparam int E_CCH   = 7;
    localparam int E_WR    = 2;
    localparam int E_VLD   = 1;

    typedef struct packed {
        logic [PPN_W-1:0] ppn;
        logic             wr;
        logic             cch;
    } tc_data_t;
endpackage

// File: rtl/iova_regs.sv
`timescale 1ns/1ps
module iova_regs
    import iova_pkg::*;
#(
    parameter int SLOTS  = 4,
    parameter int CFG_AW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic              xlate_en,
    output logic [2:0]        range_code,
    output logic [31:0]       tbl_base,
    output logic [SLOTS-1:0]  slot_byp,
    output logic [SLOTS-1:0]  slot_b30,
    output logic              flush_all,
    output logic              flush_pg,
    output logic [VPN_W-1:0]  flush_vpn
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xlate_en   <= 1'b0;
            range_code <= 3'd0;
            tbl_base   <= 32'd0;
        end else if (cfg_we) begin
            if (cfg_addr == CFG_AW'(REG_CTRL)) begin
                xlate_en   <= cfg_wdata[0];
                range_code <= cfg_wdata[4:2];
            end
            if (cfg_addr == CFG_AW'(REG_BASE))
                tbl_base <= cfg_wdata;
        end
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_byp[s] <= 1'b0;
                slot_b30[s] <= 1'b0;
            end else if (cfg_we && cfg_addr == CFG_AW'(REG_SLOT0 + s)) begin
                slot_byp[s] <= cfg_wdata[0];
                slot_b30[s] <= cfg_wdata[16];
            end
        end
    end

    assign flush_all = cfg_we && (cfg_addr == CFG_AW'(REG_FLUSH_ALL));
    assign flush_pg  = cfg_we && (cfg_addr == CFG_AW'(REG_FLUSH_PAGE));
    assign flush_vpn = cfg_wdata[31:PG_SH];
endmodule

// File: rtl/iova_window.sv
`timescale 1ns/1ps
module iova_window
    import iova_pkg::*;
(
    input  logic [2:0]       range_code,
    input  logic [31:0]      va,
    output logic             in_win,
    output logic [PPN_W-1:0] idx
);
    logic [31:0] hi_mask;

    assign hi_mask = 32'hFFFF_FFFF << (5'd24 + {2'b00, range_code});
    assign in_win  = &(va | ~hi_mask);
    assign idx     = va[30:PG_SH] & ~hi_mask[30:PG_SH];
endmodule

// File: rtl/iova_tcache.sv
`timescale 1ns/1ps
module iova_tcache
    import iova_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [VPN_W-1:0]   lk_vpn,
    output logic               hit,
    output tc_data_t           hit_data,
    input  logic               fill_en,
    input  logic [VPN_W-1:0]   fill_vpn,
    input  tc_data_t           fill_data,
    input  logic               flush_all,
    input  logic               flush_pg,
    input  logic [VPN_W-1:0]   flush_vpn,
    output logic [ENTRIES-1:0] valid_vec
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [VPN_W-1:0]   tag [ENTRIES];
    tc_data_t           dat [ENTRIES];
    logic [ENTRIES-1:0] match;
    logic [PTR_W-1:0]   rr_ptr;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        assign match[e] = valid_vec[e] && (tag[e] == lk_vpn);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_vec[e] <= 1'b0;
                tag[e]       <= '0;
                dat[e]       <= '0;
            end else if (flush_all) begin
                valid_vec[e] <= 1'b0;
            end else if (flush_pg && tag[e] == flush_vpn) begin
                valid_vec[e] <= 1'b0;
            end else if (fill_en && rr_ptr == PTR_W'(e)) begin
                valid_vec[e] <= 1'b1;
                tag[e]       <= fill_vpn;
                dat[e]       <= fill_data;
            end
        end
    end

    always_comb begin
        hit      = |match;
        hit_data = '0;
        for (int e = 0; e < ENTRIES; e++)
            if (match[e]) hit_data = hit_data | dat[e];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rr_ptr <= '0;
        else if (fill_en)
            rr_ptr <= (rr_ptr == PTR_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
    end
endmodule

// File: rtl/iova_xlate.sv
`timescale 1ns/1ps
module iova_xlate
    import iova_pkg::*;
#(
    parameter int TC_ENTRIES = 8,
    parameter int SLOTS      = 4,
    parameter int CFG_AW     = $clog2(SLOTS + REG_SLOT0),
    parameter int SLOT_W     = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_va,
    input  logic              req_write,
    input  logic [SLOT_W-1:0] req_slot,
    output logic              resp_valid,
    output logic              resp_fault,
    output logic [30:0]       resp_pa,
    output logic              resp_cacheable,
    output logic              mem_req,
    output logic [31:0]       mem_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata
);
    walk_state_t state, state_nx;

    logic                  xlate_en;
    logic [2:0]            range_code;
    logic [31:0]           tbl_base;
    logic [SLOTS-1:0]      slot_byp, slot_b30;
    logic                  flush_all, flush_pg;
    logic [VPN_W-1:0]      flush_vpn;
    logic                  in_win;
    logic [PPN_W-1:0]      win_idx;
    logic                  tc_hit;
    tc_data_t              tc_data;
    logic [TC_ENTRIES-1:0] tc_valid;

    logic [31:0] va_q, maddr_q;
    logic        wr_q, stale_q;
    logic        res_fault, res_cch;
    logic [30:0] res_pa;

    logic        accept, bypass_sel, any_flush;
    logic        fast_done, fast_fault, fast_cch;
    logic [30:0] fast_pa;
    logic        walk_fault, walk_cch, fill_en;
    logic [30:0] walk_pa;
    tc_data_t    fill_data;

    iova_regs #(.SLOTS(SLOTS), .CFG_AW(CFG_AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .xlate_en(xlate_en), .range_code(range_code),
        .tbl_base(tbl_base), .slot_byp(slot_byp), .slot_b30(slot_b30),
        .flush_all(flush_all), .flush_pg(flush_pg), .flush_vpn(flush_vpn)
    );

    iova_window u_win (
        .range_code(range_code), .va(req_va), .in_win(in_win), .idx(win_idx)
    );

    iova_tcache #(.ENTRIES(TC_ENTRIES)) u_tc (
        .clk(clk), .rst_n(rst_n), .lk_vpn(req_va[31:PG_SH]),
        .hit(tc_hit), .hit_data(tc_data),
        .fill_en(fill_en), .fill_vpn(va_q[31:PG_SH]), .fill_data(fill_data),
        .flush_all(flush_all), .flush_pg(flush_pg), .flush_vpn(flush_vpn),
        .valid_vec(tc_valid)
    );

    assign accept     = req_valid && (state == ST_IDLE);
    assign bypass_sel = slot_byp[req_slot];
    assign any_flush  = flush_all || flush_pg;

    // Decision for requests answered without a table read
    always_comb begin
        fast_done  = 1'b1;
        fast_fault = 1'b0;
        fast_cch   = 1'b0;
        fast_pa    = '0;
        if (bypass_sel) begin
            fast_pa = {slot_b30[req_slot], req_va[29:0]};
        end else if (!xlate_en) begin
            fast_pa = req_va[30:0];
        end else if (!in_win) begin
            fast_fault = 1'b1;
        end else if (tc_hit) begin
            if (req_write && !tc_data.wr) begin
                fast_fault = 1'b1;
            end else begin
                fast_pa  = {tc_data.ppn, req_va[PG_SH-1:0]};
                fast_cch = tc_data.cch;
            end
        end else begin
            fast_done = 1'b0;
        end
    end

    // Decode of a fetched table entry
    always_comb begin
        fill_data.ppn = mem_rdata[E_PPN_HI:E_PPN_LO];
        fill_data.wr  = mem_rdata[E_WR];
        fill_data.cch = mem_rdata[E_CCH];
        walk_fault    = !mem_rdata[E_VLD] || (wr_q && !mem_rdata[E_WR]);
        walk_pa       = walk_fault ? '0 : {fill_data.ppn, va_q[PG_SH-1:0]};
        walk_cch      = walk_fault ? 1'b0 : fill_data.cch;
        fill_en       = (state == ST_FETCH) && mem_rvalid && mem_rdata[E_VLD]
                        && !stale_q && !any_flush;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept) state_nx = fast_done ? ST_RESP : ST_FETCH;
            ST_FETCH: if (mem_rvalid) state_nx = ST_RESP;
            ST_RESP:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready      = (state == ST_IDLE);
        mem_req        = (state == ST_FETCH);
        resp_valid     = (state == ST_RESP);
        mem_addr       = maddr_q;
        resp_fault     = res_fault;
        resp_pa        = res_pa;
        resp_cacheable = res_cch;
    end

    // Request and result holding registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q      <= '0;
            wr_q      <= 1'b0;
            maddr_q   <= '0;
            stale_q   <= 1'b0;
            res_fault <= 1'b0;
            res_cch   <= 1'b0;
            res_pa    <= '0;
        end else if (accept) begin
            va_q      <= req_va;
            wr_q      <= req_write;
            maddr_q   <= tbl_base + 32'({win_idx, 2'b00});
            stale_q   <= 1'b0;
            res_fault <= fast_fault;
            res_cch   <= fast_cch;
            res_pa    <= fast_pa;
        end else if (state == ST_FETCH) begin
            if (any_flush) stale_q <= 1'b1;
            if (mem_rvalid) begin
                res_fault <= walk_fault;
                res_cch   <= walk_cch;
                res_pa    <= walk_pa;
            end
        end
    end
endmodule

// File: rtl/iova_xlate_chk.sv
`timescale 1ns/1ps
module iova_xlate_chk #(
    parameter int ENTRIES = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic               resp_valid,
    input logic               resp_fault,
    input logic               mem_req,
    input logic [31:0]        mem_addr,
    input logic               mem_rvalid,
    input logic               bypass_sel,
    input logic               xlate_en,
    input logic               in_win,
    input logic               tc_hit,
    input logic               flush_all,
    input logic [ENTRIES-1:0] tc_valid
);
    // R2: responses are single-cycle pulses followed by idle
    a_r2_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid && req_ready);

    // R3: bypassed slot answers directly without a fault or table read
    a_r3_bypass_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && bypass_sel) |=> resp_valid && !resp_fault && !mem_req);

    // R4: enabled translation outside the window faults at once
    a_r4_outside_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !bypass_sel && xlate_en && !in_win)
        |=> resp_valid && resp_fault);

    // R5: table read held with a stable address until answered
    a_r5_fetch_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> mem_req && $stable(mem_addr));

    // R9: a cache hit inside the window skips the table read
    a_r9_hit_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !bypass_sel && xlate_en && in_win && tc_hit)
        |=> resp_valid && !mem_req);

    // R11: flush-all empties the cache
    a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (tc_valid == '0));
endmodule

bind iova_xlate iova_xlate_chk #(.ENTRIES(TC_ENTRIES)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_fault(resp_fault), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .bypass_sel(bypass_sel),
    .xlate_en(xlate_en), .in_win(in_win), .tc_hit(tc_hit),
    .flush_all(flush_all), .tc_valid(tc_valid)
);

// File: tb/iova_xlate_bench.sv
`timescale 1ns/1ps
module iova_xlate_bench;
    localparam logic [31:0] BASE = 32'h0010_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_slot = '0;
    logic        resp_valid, resp_fault, resp_cacheable;
    logic [30:0] resp_pa;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;

    logic        r_fault, r_cch, r_mem;
    logic [30:0] r_pa;
    logic [31:0] r_maddr;
    int          r_lat;

    always #2.5 clk = ~clk;

    iova_xlate u_iova_xlate (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .req_write(req_write), .req_slot(req_slot),
        .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_pa(resp_pa),
        .resp_cacheable(resp_cacheable), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    // Page table contents, computed from the entry index
    function automatic logic [31:0] pte_of(input int unsigned i);
        logic [18:0] ppn;
        ppn = 19'((i * 37 + 5) & 32'h7FFFF);
        return {5'b0, ppn, i[0], 4'b0, (i % 3) != 0, (i % 5) != 4, 1'b0};
    endfunction

    function automatic logic [31:0] win_start(input int n);
        return 32'hFFFF_FFFF << (24 + n);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // One request; fl injects a register-3 write during the table read
    task automatic do_req(input logic [31:0] va, input logic wr,
                          input logic [1:0] slot, input bit fl);
        bit fl_done = 0;
        @(negedge clk);
        req_valid = 1'b1; req_va = va; req_write = wr; req_slot = slot;
        @(negedge clk);
        req_valid = 1'b0;
        r_lat = 1; r_mem = 1'b0; r_maddr = '0;
        while (!resp_valid && r_lat < 50) begin
            if (mem_req) begin
                r_mem = 1'b1; r_maddr = mem_addr;
                if (fl && !fl_done) begin
                    cfg_we = 1'b1; cfg_addr = 3'd3; cfg_wdata = 32'h0000_1000;
                    fl_done = 1; mem_rvalid = 1'b0;
                end else begin
                    cfg_we = 1'b0; mem_rvalid = 1'b1;
                    mem_rdata = pte_of((mem_addr - BASE) >> 2);
                end
            end
            @(negedge clk);
            r_lat++;
        end
        mem_rvalid = 1'b0; cfg_we = 1'b0;
        r_fault = resp_fault; r_pa = resp_pa; r_cch = resp_cacheable;
    endtask

    // Translated access in window n with fully computed expectations
    task automatic xl(input logic [31:0] va, input logic wr, input int n,
                      input bit exp_hit, input string tag);
        int unsigned i;
        logic [31:0] e;
        logic        flt, ec;
        logic [30:0] epa;
        i   = (va - win_start(n)) >> 12;
        e   = pte_of(i);
        flt = !e[1] || (wr && !e[2]);
        epa = flt ? 31'd0 : {e[26:8], va[11:0]};
        ec  = flt ? 1'b0 : e[7];
        do_req(va, wr, 2'd0, 0);
        chk(r_fault == flt, {tag, " fault"}, 64'(r_fault), 64'(flt));
        chk(r_pa == epa, {tag, " pa"}, 64'(r_pa), 64'(epa));
        chk(r_cch == ec, {tag, " cacheable"}, 64'(r_cch), 64'(ec));
        if (exp_hit)
            chk(!r_mem && r_lat == 1, {tag, " R9 hit"}, 64'(r_lat), 64'd1);
        else
            chk(r_mem && r_lat == 2 && r_maddr == BASE + i * 4, {tag, " R5 miss addr"},
                64'(r_maddr), 64'(BASE + i * 4));
    endtask

    function automatic logic [31:0] va7(input int unsigned i);
        return 32'h8000_0000 + (i << 12) + 32'h0000_0A5C;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned lst[9] = '{10, 11, 12, 13, 15, 16, 17, 18, 20};
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready && !resp_valid && !mem_req, "R1 reset outputs",
            64'({req_ready, resp_valid, mem_req}), 64'b100);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 translation disabled: pass-through
        for (int k = 0; k < 6; k++) begin
            logic [31:0] va;
            va = 32'h1357_9BDF * (k + 1) + 32'h0F00_0000 * k;
            do_req(va, k[0], 2'(k % 4), 0);
            chk(!r_fault && r_pa == va[30:0] && !r_mem && r_lat == 1, "R2 passthrough",
                64'(r_pa), 64'(va[30:0]));
        end

        // R3 bypass with translation off, both bit-30 sources
        cfg_write(3'd5, 32'h0001_0001);
        do_req(32'h1234_5678, 1'b0, 2'd1, 0);
        chk(!r_fault && r_pa == 31'h5234_5678 && !r_mem, "R3 bypass b30=1",
            64'(r_pa), 64'h5234_5678);
        cfg_write(3'd5, 32'h0000_0001);
        do_req(32'h7234_5678, 1'b1, 2'd1, 0);
        chk(!r_fault && r_pa == 31'h3234_5678 && !r_mem, "R3 bypass b30=0",
            64'(r_pa), 64'h3234_5678);

        // R4/R5/R6 sweep of every range code
        cfg_write(3'd1, BASE);
        cfg_write(3'd6, 32'h0001_0001);
        for (int n = 0; n < 8; n++) begin
            logic [31:0] st;
            st = win_start(n);
            cfg_write(3'd0, 32'(n << 2) | 32'd1);
            cfg_write(3'd2, 32'd0);
            do_req(st - 1, 1'b0, 2'd0, 0);
            chk(r_fault && r_pa == 31'd0 && !r_mem && r_lat == 1, "R4 below window",
                64'({r_fault, r_mem}), 64'b10);
            xl(st + 32'h5ABC, 1'b0, n, 0, "R6 index5");
            xl(32'hFFFF_F123, 1'b0, n, 0, "R6 top");
            xl(st + 32'h5ABC, 1'b0, n, 1, "R9 index5 again");
            do_req(st - 1, 1'b0, 2'd2, 0);
            chk(!r_fault && r_pa == {1'b1, st[29:0] - 30'd1} && !r_mem, "R3 bypass enabled",
                64'(r_pa), 64'({1'b1, st[29:0] - 30'd1}));
        end

        // R7 invalid entry (index 4) never cached
        cfg_write(3'd2, 32'd0);
        xl(va7(4), 1'b0, 7, 0, "R7 invalid first");
        xl(va7(4), 1'b0, 7, 0, "R7 invalid again");

        // R8 write to read-only entry (index 3), then read hits
        xl(va7(3), 1'b1, 7, 0, "R8 write fault");
        xl(va7(3), 1'b0, 7, 1, "R8 read after");
        xl(va7(7), 1'b1, 7, 0, "R8 writable ok");

        // R10 round-robin capacity
        cfg_write(3'd2, 32'hFFFF_FFFF);
        foreach (lst[j]) xl(va7(lst[j]), 1'b0, 7, 0, "R10 fill");
        for (int j = 1; j < 9; j++) xl(va7(lst[j]), 1'b0, 7, 1, "R10 kept");
        xl(va7(lst[0]), 1'b0, 7, 0, "R10 evicted");

        // R11 flush all
        cfg_write(3'd2, 32'hA5A5_A5A5);
        xl(va7(20), 1'b0, 7, 0, "R11 after flush");
        xl(va7(12), 1'b0, 7, 0, "R11 after flush b");

        // R12 flush one page
        cfg_write(3'd2, 32'd0);
        xl(va7(12), 1'b0, 7, 0, "R12 fill a");
        xl(va7(13), 1'b0, 7, 0, "R12 fill b");
        cfg_write(3'd3, va7(12) | 32'h0000_0FFF);
        xl(va7(13), 1'b0, 7, 1, "R12 other kept");
        xl(va7(12), 1'b0, 7, 0, "R12 page dropped");

        // R13 flush during outstanding read
        cfg_write(3'd2, 32'd0);
        do_req(va7(15), 1'b0, 2'd0, 1);
        chk(!r_fault && r_pa == {pte_of(15)[26:8], 12'hA5C} && r_lat == 3,
            "R13 response", 64'(r_pa), 64'({pte_of(15)[26:8], 12'hA5C}));
        xl(va7(15), 1'b0, 7, 0, "R13 not cached");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule